// File: doc/BRIEF.md
# ADC Result and Selection Register

This block sits between an analog-to-digital converter and a byte-wide register bus. It stores the latest 10-bit conversion result and shows it as two byte registers, low and high. A single adjust bit chooses how the result is shown. Right-adjusted places the value at the bottom of the 16-bit pair. Left-adjusted places it at the top, so the high byte alone gives an 8-bit reading.

The block also holds the byte-wide selection register: reference choice, adjust bit and channel/gain code. The reference and channel values that software writes are passed to the converter only between conversions. The adjust bit works on the view at once.

A bus read of the low byte freezes the stored result until the high byte is read, so the two halves always come from the same conversion. A conversion result that arrives on the `cv_valid`/`cv_data` stream is always taken in the cycle it is offered (`cv_ready` is held high and no back-pressure exists). It is dropped if the freeze is active.

Top module: `adc_result_regs`

## Requirements
- R1: After reset the selection register, the stored result and both effective selections are zero, and every bus address reads 0x00.
- R2: The selection register at address 2 holds the reference code in bits 7..6, the adjust bit in bit 5 and the channel/gain code in bits 4..0. A write there reads back unchanged.
- R3: While `conv_active` is low, a selection write drives its reference and channel fields onto `eff_ref`/`eff_chan` at the clock edge that takes the write.
- R4: While `conv_active` is high, `eff_ref`/`eff_chan` keep their values. At the edge where `cv_valid` is high they take the current selection fields.
- R5: With the adjust bit at 0, address 1 (high) reads {6'b0, result[9:8]} and address 0 (low) reads result[7:0]. For 0x320 these are 0x03 and 0x20.
- R6: With the adjust bit at 1, the high byte reads result[9:2] and the low byte reads {result[1:0], 6'b0}. For 0x320 these are 0xC8 and 0x00.
- R7: A change of the adjust bit alters the bytes read from the next cycle on, even while `conv_active` is high.
- R8: A read of address 0 sets a freeze. While it is set, a result on `cv_valid` is dropped, the stored result keeps its value and `res_done` stays low.
- R9: A read of address 1 clears the freeze. Later results are stored again.
- R10: Each stored result gives `res_done` high for exactly the one cycle after the edge that stored it. This includes results arriving on back-to-back cycles.
- R11: Result bits outside the chosen view read as zero. For 0x3FF, right adjust gives high 0x03 and left adjust gives low 0xC0.
- R12: `cv_ready` is high in every cycle after reset.
- R13: Writes to addresses 0, 1 and 3 change nothing, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_active | input | 1 | Converter is in the middle of a conversion |
| cv_valid | input | 1 | Conversion result offered this cycle |
| cv_data | input | 10 | Conversion result value |
| cv_ready | output | 1 | Result accepted (always high) |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe (drives the freeze) |
| bus_addr | input | 2 | 0 low byte, 1 high byte, 2 selection, 3 unused |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data for `bus_addr` |
| eff_ref | output | 2 | Reference code applied to the converter |
| eff_chan | output | 5 | Channel/gain code applied to the converter |
| res_done | output | 1 | One-cycle pulse after a result is stored |

## Verification
The two views are read with 0x320 and 0x3FF, and the drop tests use 0x155. 0x320 separates the high and low halves and checks the example byte values. 0x3FF sets every result bit, so a stray bit outside the view shows up at once. 0x155 has alternating bits and comes after results whose bytes differ from it, so a dropped or stored value is plain to see.

Selection writes are made both with `conv_active` low and with it high, which tells immediate application apart from staging. Each result is offered in one of three ways: alone, inside a freeze window, or on two back-to-back cycles. These tell storing, dropping and pulse counting apart.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;
  localparam int BYTE_W = 8;
  localparam int REF_W  = 2;
  localparam int CHAN_W = 5;

  typedef enum logic [1:0] {
    A_LOW  = 2'd0,
    A_HIGH = 2'd1,
    A_SEL  = 2'd2,
    A_NONE = 2'd3
  } rr_addr_e;

  typedef struct packed {
    logic [REF_W-1:0]  refsel;
    logic              ladj;
    logic [CHAN_W-1:0] chan;
  } sel_t;
endpackage

// File: rtl/adc_rr_sel.sv
module adc_rr_sel
  import adc_rr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  sel_t              wr_val,
  input  logic              conv_active,
  input  logic              cv_valid,
  output sel_t              sel_q,
  output logic [REF_W-1:0]  eff_ref,
  output logic [CHAN_W-1:0] eff_chan
);
  sel_t sel_nxt;
  logic apply;

  // A write landing in the boundary cycle is carried straight through.
  always_comb begin
    sel_nxt = wr_en ? wr_val : sel_q;
    apply   = !conv_active || cv_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      eff_ref  <= '0;
      eff_chan <= '0;
    end else begin
      sel_q <= sel_nxt;
      if (apply) begin
        eff_ref  <= sel_nxt.refsel;
        eff_chan <= sel_nxt.chan;
      end
    end
  end
endmodule

// File: rtl/adc_rr_hold.sv
module adc_rr_hold #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cv_valid,
  input  logic [RES_W-1:0] cv_data,
  input  logic             rd_low,
  input  logic             rd_high,
  output logic [RES_W-1:0] res_q,
  output logic             lock_q,
  output logic             res_done
);
  logic take;

  // A low-byte read in the same cycle already blocks the update.
  always_comb take = cv_valid && !lock_q && !rd_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q    <= '0;
      lock_q   <= 1'b0;
      res_done <= 1'b0;
    end else begin
      res_done <= take;
      if (take) res_q <= cv_data;
      if (rd_low)       lock_q <= 1'b1;
      else if (rd_high) lock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_rr_view.sv
module adc_rr_view #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  res,
  input  logic              ladj,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte
);
  localparam int FULL_W = 2 * BYTE_W;
  localparam int PAD    = FULL_W - RES_W;

  logic [FULL_W-1:0] right_v;
  logic [FULL_W-1:0] left_v;
  logic [FULL_W-1:0] pick;

  generate
    if (PAD > 0) begin : g_pad
      assign right_v = {{PAD{1'b0}}, res};
      assign left_v  = {res, {PAD{1'b0}}};
    end else begin : g_full
      assign right_v = res;
      assign left_v  = res;
    end
  endgenerate

  always_comb begin
    pick    = ladj ? left_v : right_v;
    lo_byte = pick[BYTE_W-1:0];
    hi_byte = pick[FULL_W-1:BYTE_W];
  end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_rr_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_active,
  input  logic             cv_valid,
  input  logic [RES_W-1:0] cv_data,
  output logic             cv_ready,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [1:0]       eff_ref,
  output logic [4:0]       eff_chan,
  output logic             res_done
);
  rr_addr_e          addr;
  sel_t              sel_q;
  logic              sel_wr;
  logic              rd_low;
  logic              rd_high;
  logic              lock_q;
  logic [RES_W-1:0]  res_q;
  logic [BYTE_W-1:0] lo_b;
  logic [BYTE_W-1:0] hi_b;
  logic              ladj;

  always_comb begin
    addr    = rr_addr_e'(bus_addr);
    sel_wr  = bus_we && (addr == A_SEL);
    rd_low  = bus_re && (addr == A_LOW);
    rd_high = bus_re && (addr == A_HIGH);
    ladj    = sel_q.ladj;
  end

  assign cv_ready = 1'b1;

  adc_rr_sel u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (sel_wr),
    .wr_val      (sel_t'(bus_wdata)),
    .conv_active (conv_active),
    .cv_valid    (cv_valid),
    .sel_q       (sel_q),
    .eff_ref     (eff_ref),
    .eff_chan    (eff_chan)
  );

  adc_rr_hold #(.RES_W(RES_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .cv_valid (cv_valid),
    .cv_data  (cv_data),
    .rd_low   (rd_low),
    .rd_high  (rd_high),
    .res_q    (res_q),
    .lock_q   (lock_q),
    .res_done (res_done)
  );

  adc_rr_view #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_view (
    .res     (res_q),
    .ladj    (ladj),
    .lo_byte (lo_b),
    .hi_byte (hi_b)
  );

  always_comb begin
    unique case (addr)
      A_LOW:   bus_rdata = lo_b;
      A_HIGH:  bus_rdata = hi_b;
      A_SEL:   bus_rdata = sel_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/adc_rr_chk.sv
module adc_rr_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             conv_active,
  input logic             cv_valid,
  input logic [RES_W-1:0] cv_data,
  input logic             cv_ready,
  input logic             bus_we,
  input logic             bus_re,
  input logic [1:0]       bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [7:0]       bus_rdata,
  input logic [1:0]       eff_ref,
  input logic [4:0]       eff_chan,
  input logic             res_done,
  input logic             lock_q,
  input logic [RES_W-1:0] res_q,
  input logic             ladj
);
  localparam int HI_USED = RES_W - 8;
  localparam int LO_FREE = 16 - RES_W;

  a_r3_idle_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_active && bus_we && bus_addr == 2'd2) |=>
      (eff_chan == $past(bus_wdata[4:0]) && eff_ref == $past(bus_wdata[7:6])));

  a_r4_staged_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && !cv_valid) |=> ($stable(eff_ref) && $stable(eff_chan)));

  a_r8_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == 2'd0) |=> lock_q);

  a_r8_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && cv_valid) |=> (!res_done && $stable(res_q)));

  a_r9_store: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_valid && !lock_q && !(bus_re && bus_addr == 2'd0)) |=>
      (res_done && res_q == $past(cv_data)));

  a_r10_done_src: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(cv_valid));

  a_r11_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ladj && bus_addr == 2'd1) |-> ((bus_rdata >> HI_USED) == 8'd0));

  a_r11_lo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ladj && bus_addr == 2'd0) |-> ((bus_rdata << (8 - LO_FREE)) == 8'd0));

  a_r12_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cv_ready);
endmodule

bind adc_result_regs adc_rr_chk #(.RES_W(RES_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_active (conv_active),
  .cv_valid    (cv_valid),
  .cv_data     (cv_data),
  .cv_ready    (cv_ready),
  .bus_we      (bus_we),
  .bus_re      (bus_re),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .eff_ref     (eff_ref),
  .eff_chan    (eff_chan),
  .res_done    (res_done),
  .lock_q      (lock_q),
  .res_q       (res_q),
  .ladj        (ladj)
);

// File: tb/sim_adc_result_regs.sv
`timescale 1ns/1ps
module sim_adc_result_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_active = 1'b0;
  logic       cv_valid = 1'b0;
  logic [9:0] cv_data = '0;
  logic       cv_ready;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] eff_ref;
  logic [4:0] eff_chan;
  logic       res_done;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_q [$];

  always #4 clk = ~clk;

  adc_result_regs u0 (
    .clk(clk), .rst_n(rst_n), .conv_active(conv_active),
    .cv_valid(cv_valid), .cv_data(cv_data), .cv_ready(cv_ready),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eff_ref(eff_ref), .eff_chan(eff_chan), .res_done(res_done)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // Monitor: every completion pulse must match a queued expected store.
  always @(negedge clk) begin
    if (rst_n && res_done) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected res_done actual=1 expected=0");
      end else begin
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  // Driver: offers one result and queues it when it should be stored.
  task automatic conv(input logic [9:0] v, input logic accept, input string req);
    @(negedge clk);
    cv_valid = 1'b1; cv_data = v;
    if (accept) exp_q.push_back(v);
    @(negedge clk);
    cv_valid = 1'b0;
    chk(req, {7'd0, res_done}, {7'd0, accept});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 eff_ref", {6'd0, eff_ref}, 8'h00);
    chk("R1 eff_chan", {3'd0, eff_chan}, 8'h00);
    rd(2'd0, d); chk("R1 low", d, 8'h00);
    rd(2'd1, d); chk("R1 high", d, 8'h00);
    rd(2'd2, d); chk("R1 sel", d, 8'h00);
    rd(2'd3, d); chk("R1 addr3", d, 8'h00);
    chk("R12 ready", {7'd0, cv_ready}, 8'h01);

    // R2/R3 selection layout and idle apply
    wr(2'd2, 8'hEB);
    chk("R3 eff_ref", {6'd0, eff_ref}, 8'h03);
    chk("R3 eff_chan", {3'd0, eff_chan}, 8'h0B);
    rd(2'd2, d); chk("R2 readback", d, 8'hEB);

    // R6 left view of 0x320
    conv(10'h320, 1'b1, "R10 store pulse");
    rd(2'd0, d); chk("R6 low", d, 8'h00);
    rd(2'd1, d); chk("R6 high", d, 8'hC8);

    // R5/R7 right view after clearing adjust
    wr(2'd2, 8'hCB);
    rd(2'd0, d); chk("R5 low", d, 8'h20);
    rd(2'd1, d); chk("R5 high", d, 8'h03);

    // R4 staging during a conversion, R7 adjust immediate
    conv_active = 1'b1;
    wr(2'd2, 8'h25);
    chk("R4 ref held", {6'd0, eff_ref}, 8'h03);
    chk("R4 chan held", {3'd0, eff_chan}, 8'h0B);
    rd(2'd1, d); chk("R7 high during conv", d, 8'hC8);
    rd(2'd2, d); chk("R2 staged readback", d, 8'h25);
    conv(10'h3FF, 1'b1, "R10 store pulse");
    chk("R4 ref at boundary", {6'd0, eff_ref}, 8'h00);
    chk("R4 chan at boundary", {3'd0, eff_chan}, 8'h05);
    conv_active = 1'b0;

    // R11 unused bits with all ones
    rd(2'd0, d); chk("R11 left low", d, 8'hC0);
    rd(2'd1, d); chk("R6 left high", d, 8'hFF);
    wr(2'd2, 8'h05);
    rd(2'd0, d); chk("R5 right low", d, 8'hFF);
    rd(2'd1, d); chk("R11 right high", d, 8'h03);

    // R8 freeze drops a result, R9 release
    rd(2'd0, d); chk("R5 low before freeze", d, 8'hFF);
    conv(10'h155, 1'b0, "R8 no pulse while frozen");
    rd(2'd1, d); chk("R8 old high kept", d, 8'h03);
    conv(10'h155, 1'b1, "R9 stored after release");
    rd(2'd0, d); chk("R9 low", d, 8'h55);
    rd(2'd1, d); chk("R9 high", d, 8'h01);

    // R13 writes to result and unused addresses ignored
    wr(2'd0, 8'hAA);
    wr(2'd1, 8'hAA);
    wr(2'd3, 8'h77);
    rd(2'd0, d); chk("R13 low", d, 8'h55);
    rd(2'd1, d); chk("R13 high", d, 8'h01);
    rd(2'd3, d); chk("R13 addr3", d, 8'h00);
    rd(2'd2, d); chk("R13 sel", d, 8'h05);

    // R10 back-to-back results
    @(negedge clk);
    cv_valid = 1'b1; cv_data = 10'h001; exp_q.push_back(10'h001);
    @(negedge clk);
    cv_data = 10'h002; exp_q.push_back(10'h002);
    chk("R10 first pulse", {7'd0, res_done}, 8'h01);
    @(negedge clk);
    cv_valid = 1'b0;
    chk("R10 second pulse", {7'd0, res_done}, 8'h01);
    @(negedge clk);
    chk("R10 pulse ends", {7'd0, res_done}, 8'h00);
    rd(2'd0, d); chk("R10 last stored low", d, 8'h02);
    rd(2'd1, d); chk("R10 last stored high", d, 8'h00);

    @(negedge clk);
    chk("R10 all stores seen", 8'(exp_q.size()), 8'h00);
    chk("R12 ready end", {7'd0, cv_ready}, 8'h01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule